// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a two-wire (I2C) slave that lets an external bus master read and write a 64-byte register file. The system clock oversamples the SCL and SDA lines. The block drives SDA open-drain through a single pull-low enable. It recognises START, repeated START and STOP, and it responds only to a fixed 7-bit device address. A write transaction uses its first byte to load a 6-bit register pointer and stores any further bytes starting at that pointer. A read transaction streams bytes out starting at the pointer's present value.

The pointer is kept from one transaction to the next. It steps forward after every byte moved in either direction and wraps from the last register back to the first. A master can therefore set the pointer once and then issue plain reads that continue where the last transfer stopped. Local logic reaches every register through a parallel port that has an asynchronous read and a synchronous write.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), all registers read 0x00 and the pointer is 0.
- R2: An address byte of 0xD0 (address 1101000, R/W = 0, write) or 0xD1 (R/W = 1, read) is acknowledged by pulling SDA low in the ninth clock. Bytes are shifted most significant bit first.
- R3: After any other address byte, the slave gives no acknowledge, keeps SDA released and changes no register until the next START or STOP.
- R4: In a write, the first byte after the address is acknowledged and loads the pointer from its low 6 bits. Bits 7:6 are ignored.
- R5: Each later write byte is acknowledged, stored at the pointer in the acknowledge clock, and the pointer then increments.
- R6: A read sends the register at the pointer, MSB first, and the pointer increments after each byte sent.
- R7: The pointer keeps its value across transactions, so a read with no pointer write continues from where the last transaction left it.
- R8: The pointer wraps from 63 to 0 in both reads and writes.
- R9: During a read, a master acknowledge (SDA low) makes the slave send the next byte. A not-acknowledge (SDA high) ends the read and leaves SDA released.
- R10: A repeated START begins a new address phase, so a write that only sets the pointer can be followed directly by a read from that register.
- R11: The slave changes SDA only while SCL is low.
- R12: Local logic can write any register through `loc_we_i`/`loc_addr_i`/`loc_wdata_i` and read any register on `loc_rdata_o`. The bus sees these values.
- R13: A STOP in the middle of a byte abandons that byte: no register is written and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| loc_we_i | input | 1 | Local write strobe |
| loc_addr_i | input | 6 | Local register index |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Register contents at `loc_addr_i` |

## Verification
The hardest state to reach from the ports is a read that crosses the wrap of the pointer while the pointer was left over from earlier transactions rather than written just before. To reach it, the stimulus first runs a burst write that starts at register 62, crosses the end of the file and leaves the pointer at a known low value. It then issues a plain read with no pointer write, and after that a burst read from 62 that is acknowledged twice and closed with a not-acknowledge. The same pattern is repeated with a repeated START placed between the pointer write and the read, and with a STOP cut into the middle of a byte. This shows that the pointer survives each kind of interruption.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // bus idles high, so reset to ones to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          loc_we_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic [DW-1:0] loc_rdata_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  // bus write wins a same-entry collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bus_we_i && bus_addr_i == AW'(i))
          mem_q[i] <= bus_wdata_i;
        else if (loc_we_i && loc_addr_i == AW'(i))
          mem_q[i] <= loc_wdata_i;
      end
    end
  end

  assign bus_rdata_o = mem_q[bus_addr_i];
  assign loc_rdata_o = mem_q[loc_addr_i];

  assert_bus_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |=> mem_q[$past(bus_addr_i)] == $past(bus_wdata_i));

  assert_loc_store_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_we_i && !(bus_we_i && bus_addr_i == loc_addr_i))
      |=> mem_q[$past(loc_addr_i)] == $past(loc_wdata_i));
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_regptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         REG_DEPTH   = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       loc_we_i,
  input  logic [5:0] loc_addr_i,
  input  logic [7:0] loc_wdata_i,
  output logic [7:0] loc_rdata_o
);
  localparam int PTR_W = $clog2(REG_DEPTH);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  slv_state_e state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       shreg_q, tx_q;
  logic             rw_q, ptr_phase_q, nack_q, oe_q;
  logic [PTR_W-1:0] ptr_q;
  logic             bus_we, ptr_inc;
  logic [7:0]       bus_rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_regfile #(.DEPTH(REG_DEPTH), .DW(8), .AW(PTR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we),
    .bus_addr_i  (ptr_q),
    .bus_wdata_i (shreg_q),
    .bus_rdata_o (bus_rdata),
    .loc_we_i    (loc_we_i),
    .loc_addr_i  (loc_addr_i[PTR_W-1:0]),
    .loc_wdata_i (loc_wdata_i),
    .loc_rdata_o (loc_rdata_o)
  );

  // data commit happens on the rising edge of the acknowledge clock
  assign bus_we  = (state_q == ST_RX_ACK) && scl_rise && !ptr_phase_q;
  assign ptr_inc = bus_we || ((state_q == ST_TX) && scl_fall && cnt_q == BYTE_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shreg_q     <= '0;
      tx_q        <= '0;
      rw_q        <= 1'b0;
      ptr_phase_q <= 1'b0;
      nack_q      <= 1'b0;
      oe_q        <= 1'b0;
      ptr_q       <= '0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != BYTE_BITS) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            cnt_q   <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            if (shreg_q[7:1] == DEV_ADDR) begin
              rw_q    <= shreg_q[0];
              oe_q    <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= bus_rdata;
              oe_q    <= ~bus_rdata[7];
              state_q <= ST_TX;
            end else begin
              oe_q        <= 1'b0;
              ptr_phase_q <= 1'b1;
              state_q     <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && cnt_q != BYTE_BITS) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            cnt_q   <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            oe_q    <= 1'b1;
            state_q <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_rise) begin
            if (ptr_phase_q) ptr_q <= shreg_q[PTR_W-1:0];
            else             ptr_q <= ptr_q + 1'b1;
          end else if (scl_fall) begin
            oe_q        <= 1'b0;
            ptr_phase_q <= 1'b0;
            cnt_q       <= '0;
            state_q     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != BYTE_BITS) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BYTE_BITS) begin
              oe_q    <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_TX_ACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_q <= ST_IGNORE;
            end else begin
              tx_q    <= bus_rdata;
              oe_q    <= ~bus_rdata[7];
              cnt_q   <= '0;
              state_q <= ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  assert_sda_hold_scl_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && !start_det && !stop_det) |=> $stable(sda_oe_o));

  assert_ignore_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_oe_o);

  assert_master_ack_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_ACK) |-> !sda_oe_o);

  assert_rx_ack_driven_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_ACK) |-> sda_oe_o);

  assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_inc |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
endmodule

// File: tb/i2c_regptr_slave_bench.sv
module i2c_regptr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam logic [1:0] K_WR = 2'd0, K_PTR = 2'd1, K_RD = 2'd2;
  localparam int NVEC = 9;
  // {kind, pointer byte, data / expected}
  localparam logic [17:0] VECS [NVEC] = '{
    {K_WR,  8'h05, 8'hA5},
    {K_WR,  8'h06, 8'h3C},
    {K_PTR, 8'h05, 8'h00},
    {K_RD,  8'h00, 8'hA5},
    {K_RD,  8'h00, 8'h3C},
    {K_WR,  8'h47, 8'h81},
    {K_PTR, 8'h07, 8'h00},
    {K_RD,  8'h00, 8'h81},
    {K_RD,  8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic loc_we = 1'b0;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  int nchk = 0, nfail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regptr_slave u_i2c_regptr_slave (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .loc_we_i    (loc_we),
    .loc_addr_i  (loc_addr),
    .loc_wdata_i (loc_wdata),
    .loc_rdata_o (loc_rdata)
  );

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(2); scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(2); sda_m = 1'b0; wq(2); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(2); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      wq(1); sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    ack = ~sda_bus;
    wq(1); scl_m = 1'b0;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(2); scl_m = 1'b1; wq(1); b[i] = sda_bus; wq(1); scl_m = 1'b0;
    end
    wq(1); sda_m = nack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic loc_write(input logic [5:0] a, input logic [7:0] d);
    loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    @(negedge clk); loc_we = 1'b0;
  endtask

  task automatic loc_check(input string req, input logic [5:0] a, input logic [7:0] exp);
    loc_addr = a; @(negedge clk);
    check(req, loc_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 sda released", {7'd0, sda_oe}, 8'h00);
    loc_check("R1 reg5 zero", 6'd5, 8'h00);
    bus_start(); wr_byte(8'hD1, ack);
    check("R2 read addr ack", {7'd0, ack}, 8'h01);
    rd_byte(1'b1, rd); bus_stop();
    check("R1 pointer zero read", rd, 8'h00);

    // table of single-byte transactions
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] k;
      k = VECS[v][17:16];
      bus_start();
      if (k == K_RD) begin
        wr_byte(8'hD1, ack);
        check("R2 read addr ack", {7'd0, ack}, 8'h01);
        rd_byte(1'b1, rd);
        check("R6 R7 read data", rd, VECS[v][7:0]);
      end else begin
        wr_byte(8'hD0, ack);
        check("R2 write addr ack", {7'd0, ack}, 8'h01);
        wr_byte(VECS[v][15:8], ack);
        check("R4 pointer byte ack", {7'd0, ack}, 8'h01);
        if (k == K_WR) begin
          wr_byte(VECS[v][7:0], ack);
          check("R5 data byte ack", {7'd0, ack}, 8'h01);
        end
      end
      bus_stop();
    end
    loc_check("R4 upper bits ignored reg7", 6'd7, 8'h81);

    // wrong address ignored
    bus_start(); wr_byte(8'hA0, ack);
    check("R3 no ack on mismatch", {7'd0, ack}, 8'h00);
    wr_byte(8'h05, ack);
    check("R3 no ack after mismatch", {7'd0, ack}, 8'h00);
    wr_byte(8'hEE, ack);
    check("R3 sda released", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    loc_check("R3 reg5 unchanged", 6'd5, 8'hA5);

    // burst write across wrap, then plain read continuing from pointer
    loc_write(6'd2, 8'h99);
    loc_check("R12 local write readback", 6'd2, 8'h99);
    bus_start(); wr_byte(8'hD0, ack); wr_byte(8'd62, ack);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack); wr_byte(8'h33, ack); wr_byte(8'h44, ack);
    check("R5 burst ack", {7'd0, ack}, 8'h01);
    bus_stop();
    loc_check("R5 reg62", 6'd62, 8'h11);
    loc_check("R8 reg63", 6'd63, 8'h22);
    loc_check("R8 reg0 after wrap", 6'd0, 8'h33);
    loc_check("R12 reg1 via local", 6'd1, 8'h44);
    bus_start(); wr_byte(8'hD1, ack); rd_byte(1'b1, rd); bus_stop();
    check("R7 R8 read continues after wrap", rd, 8'h99);

    // burst read across wrap with ack, ack, nack
    bus_start(); wr_byte(8'hD0, ack); wr_byte(8'd62, ack); bus_stop();
    bus_start(); wr_byte(8'hD1, ack);
    rd_byte(1'b0, rd); check("R9 first byte", rd, 8'h11);
    rd_byte(1'b0, rd); check("R8 second byte", rd, 8'h22);
    rd_byte(1'b1, rd); check("R8 wrapped byte", rd, 8'h33);
    check("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    check("R9 line high after nack", {7'd0, sda_bus}, 8'h01);
    bus_stop();

    // repeated start: set pointer then read
    loc_write(6'd20, 8'h5A);
    bus_start(); wr_byte(8'hD0, ack); wr_byte(8'd20, ack);
    bus_rstart(); wr_byte(8'hD1, ack);
    check("R10 addr ack after rstart", {7'd0, ack}, 8'h01);
    rd_byte(1'b1, rd); bus_stop();
    check("R10 read after rstart", rd, 8'h5A);

    // stop inside a data byte
    loc_write(6'd30, 8'h77);
    bus_start(); wr_byte(8'hD0, ack); wr_byte(8'd30, ack);
    send_bits(8'hC3, 4); bus_stop();
    loc_check("R13 reg30 untouched", 6'd30, 8'h77);
    bus_start(); wr_byte(8'hD1, ack); rd_byte(1'b1, rd); bus_stop();
    check("R13 pointer kept", rd, 8'h77);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule